// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for a core whose page tables are walked by a software refill handler. It holds a fully associative set of page mappings, 4 KB pages each, and every mapping carries a 6-bit address-space identifier. The operating system can therefore switch between up to 64 processes without flushing the buffer. Any mapping may also be marked global, so that it matches whatever identifier is current.

A lookup arrives on a valid/ready request channel carrying the virtual address, the current identifier and a store flag. The answer returns one cycle later on a valid/ready response channel: a physical address, a cacheable flag and a result code. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being emptied in that same cycle. A response that is not taken stays on the pins unchanged. The three top address bits pick a segment. Two kernel segments bypass the buffer with a fixed mapping. All other segments are translated. A miss, an invalid mapping or a store to a clean page is reported as a fault code for the software handler, which then loads entries through a one-cycle write port addressed by entry index.

Top module: `xlat_buffer`

## Requirements
- R1: After reset no response is pending, `req_ready` is 1, and every entry holds page 0, identifier 0, not global, valid bit 0. A lookup of any page other than 0 then returns code 1 (miss).
- R2: A translated lookup that hits a valid entry returns code 0, `rsp_paddr` = {entry frame number, address bits 11:0}, and `rsp_cached` equal to the entry's cache flag.
- R3: An address with bits 31:29 = 3'b100 is not translated. It returns code 0, the address with bits 31:29 cleared, and `rsp_cached` = 1, for loads and stores alike.
- R4: An address with bits 31:29 = 3'b101 returns code 0, the address with bits 31:29 cleared, and `rsp_cached` = 0.
- R5: Addresses with bits 31:29 = 3'b0xx or 3'b11x are translated through the entries. The virtual page number is address bits 31:12.
- R6: An entry matches when its page number equals the request's page number and either its global flag is set or its identifier equals `req_asid`. A non-global entry does not match any other identifier.
- R7: Result codes: 0 = ok, 1 = miss (no entry matches), 2 = invalid (a matching entry has valid 0), 3 = modify (a store hits a valid entry whose dirty flag is 0). A load to a clean valid entry is ok. On any code other than 0, `rsp_paddr` is 0 and `rsp_cached` is 0.
- R8: When `wr_en` is high, the write port replaces entry `wr_idx` at the clock edge. A lookup accepted in that same cycle sees the old contents. The next accepted lookup sees the new contents.
- R9: The response is valid in the cycle after a request is accepted. While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays stable and `req_ready` is 0.
- R10: When several entries match, the lowest-numbered entry supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_asid | input | 6 | Current address-space identifier |
| req_store | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_cached | output | 1 | Access may be cached |
| rsp_code | output | 2 | 0 ok, 1 miss, 2 invalid, 3 modify |
| wr_en | input | 1 | Write an entry this cycle |
| wr_idx | input | 6 | Entry to replace |
| wr_vpn | input | 20 | New virtual page number |
| wr_asid | input | 6 | New identifier |
| wr_pfn | input | 20 | New physical frame number |
| wr_valid | input | 1 | New valid flag |
| wr_dirty | input | 1 | New dirty (writable) flag |
| wr_glob | input | 1 | New global flag |
| wr_cache | input | 1 | New cacheable flag |

## Verification
An entry refill and a lookup of the entry being replaced can land on the same clock edge. The bench provokes this by raising `wr_en` and `req_valid` in one cycle, with the write aimed at a mapped entry and a new frame number. It expects the response to carry the old frame and the following lookup of the same page to carry the new one. Response back-pressure is also applied by a periodic low `rsp_ready` while lookups stream in, so acceptance and holding of a result coincide as well.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    XL_OK      = 2'd0,
    XL_MISS    = 2'd1,
    XL_INVALID = 2'd2,
    XL_MODIFY  = 2'd3
  } xl_code_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic glob;
    logic cache;
  } xl_flags_t;
endpackage

// File: rtl/xlat_segdec.sv
module xlat_segdec #(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] vaddr,
  output logic            bypass,
  output logic            bypass_cached,
  output logic [VA_W-1:0] phys
);
  logic [2:0] seg;
  assign seg           = vaddr[VA_W-1 -: 3];
  // 100 and 101 are direct-mapped, everything else goes through the entries
  assign bypass        = (seg[2:1] == 2'b10);
  assign bypass_cached = ~seg[0];
  assign phys          = {3'b000, vaddr[VA_W-4:0]};
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam import xlat_pkg::*; #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  xl_flags_t         wr_flags,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [PFN_W-1:0]  hit_pfn,
  output xl_flags_t         hit_flags
);
  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic [PFN_W-1:0]  pfn_q  [ENTRIES];
  xl_flags_t         flg_q  [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]  sel;

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst_n) begin
        vpn_q[i]  <= '0;
        asid_q[i] <= '0;
        pfn_q[i]  <= '0;
        flg_q[i]  <= '0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        vpn_q[i]  <= wr_vpn;
        asid_q[i] <= wr_asid;
        pfn_q[i]  <= wr_pfn;
        flg_q[i]  <= wr_flags;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = (vpn_q[g] == lk_vpn) &&
                      (flg_q[g].glob || asid_q[g] == lk_asid);
  end

  // lowest index wins among several matches
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign hit_pfn   = pfn_q[sel];
  assign hit_flags = flg_q[sel];

  // R10: a reported hit always comes from a matching entry
  p_sel_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match[sel]);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer import xlat_pkg::*; #(
  parameter int VA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 64,
  parameter int VPN_W   = VA_W - PAGE_W,
  parameter int PA_W    = PFN_W + PAGE_W,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_store,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_cached,
  output logic [1:0]        rsp_code,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic              wr_glob,
  input  logic              wr_cache
);
  logic            bypass, bypass_cached;
  logic [VA_W-1:0] direct_pa;
  logic            hit;
  logic [PFN_W-1:0] hit_pfn;
  xl_flags_t       hit_flags, wr_flags;
  logic            accept;
  logic [PA_W-1:0] nxt_paddr;
  logic            nxt_cached;
  xl_code_e        nxt_code;

  assign wr_flags = '{valid: wr_valid, dirty: wr_dirty, glob: wr_glob, cache: wr_cache};

  xlat_segdec #(.VA_W(VA_W)) u_seg (
    .vaddr(req_vaddr), .bypass(bypass), .bypass_cached(bypass_cached), .phys(direct_pa)
  );

  xlat_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
  ) u_cam (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_pfn(wr_pfn), .wr_flags(wr_flags),
    .lk_vpn(req_vaddr[VA_W-1:PAGE_W]), .lk_asid(req_asid),
    .hit(hit), .hit_pfn(hit_pfn), .hit_flags(hit_flags)
  );

  always_comb begin
    nxt_paddr  = '0;
    nxt_cached = 1'b0;
    nxt_code   = XL_OK;
    if (bypass) begin
      nxt_paddr  = PA_W'(direct_pa);
      nxt_cached = bypass_cached;
    end else if (!hit) begin
      nxt_code = XL_MISS;
    end else if (!hit_flags.valid) begin
      nxt_code = XL_INVALID;
    end else if (req_store && !hit_flags.dirty) begin
      nxt_code = XL_MODIFY;
    end else begin
      nxt_paddr  = {hit_pfn, req_vaddr[PAGE_W-1:0]};
      nxt_cached = hit_flags.cache;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_cached <= 1'b0;
      rsp_code   <= XL_OK;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_paddr  <= nxt_paddr;
      rsp_cached <= nxt_cached;
      rsp_code   <= nxt_code;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
                                   $stable(rsp_cached) && $stable(rsp_code)));
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  p_kcached_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_vaddr[VA_W-1 -: 3] == 3'b100) |=>
      (rsp_code == 2'd0 && rsp_cached &&
       rsp_paddr == PA_W'({3'b000, $past(req_vaddr[VA_W-4:0])})));
  p_kuncached_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_vaddr[VA_W-1 -: 3] == 3'b101) |=>
      (rsp_code == 2'd0 && !rsp_cached &&
       rsp_paddr == PA_W'({3'b000, $past(req_vaddr[VA_W-4:0])})));
  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_paddr == '0 && !rsp_cached));
  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_code != 2'd0 || rsp_paddr[PAGE_W-1:0] == $past(req_vaddr[PAGE_W-1:0])));
endmodule

// File: tb/tb_xlat_buffer.sv
`timescale 1ns/1ps
module tb_xlat_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_store = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [5:0] req_asid = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_cached;
  logic [31:0] rsp_paddr;
  logic [1:0] rsp_code;
  logic wr_en = 1'b0, wr_valid = 1'b0, wr_dirty = 1'b0, wr_glob = 1'b0, wr_cache = 1'b0;
  logic [5:0] wr_idx = '0, wr_asid = '0;
  logic [19:0] wr_vpn = '0, wr_pfn = '0;

  int checks = 0, fails = 0, cyc = 0;
  logic stall_mode = 1'b0;
  logic [34:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  xlat_buffer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_asid(req_asid), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_cached(rsp_cached), .rsp_code(rsp_code), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_pfn(wr_pfn), .wr_valid(wr_valid),
    .wr_dirty(wr_dirty), .wr_glob(wr_glob), .wr_cache(wr_cache)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_ready <= stall_mode ? (cyc % 3 != 2) : 1'b1;
  end

  // monitor: compare each taken response with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9: unexpected response paddr=%h code=%0d, expected none", rsp_paddr, rsp_code);
      end else begin
        logic [34:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_paddr, rsp_cached, rsp_code} !== e) begin
          fails++;
          $display("FAIL %s: got paddr=%h cached=%b code=%0d, expected paddr=%h cached=%b code=%0d",
                   t, rsp_paddr, rsp_cached, rsp_code, e[34:3], e[2], e[1:0]);
        end
      end
    end
  end

  task automatic chk(input logic ok, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, expv);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [5:0] asid, input logic st,
                        input logic [31:0] ep, input logic ec, input logic [1:0] ecode,
                        input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_asid = asid; req_store = st;
    while (!req_ready) @(negedge clk);
    exp_q.push_back({ep, ec, ecode});
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic set_wr(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] asid,
                        input logic [19:0] pfn, input logic v, input logic d,
                        input logic g, input logic c);
    wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
    wr_valid = v; wr_dirty = d; wr_glob = g; wr_cache = c;
  endtask

  task automatic write_entry(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] asid,
                             input logic [19:0] pfn, input logic v, input logic d,
                             input logic g, input logic c);
    @(negedge clk);
    set_wr(idx, vpn, asid, pfn, v, d, g, c);
    wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 30 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R9 drain", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    lookup(32'h0000_5123, 6'd3, 1'b0, 32'h0, 1'b0, 2'd1, "R1 empty miss");
    lookup(32'h0000_0010, 6'd0, 1'b0, 32'h0, 1'b0, 2'd2, "R1 reset entries invalid");

    write_entry(6'd5, 20'h12345, 6'd7, 20'hABCDE, 1'b1, 1'b1, 1'b0, 1'b1);
    lookup(32'h1234_5678, 6'd7, 1'b0, 32'hABCD_E678, 1'b1, 2'd0, "R2 hit");
    lookup(32'h1234_5678, 6'd8, 1'b0, 32'h0, 1'b0, 2'd1, "R6 other asid misses");

    write_entry(6'd9, 20'h00400, 6'd1, 20'h00777, 1'b1, 1'b0, 1'b1, 1'b0);
    lookup(32'h0040_0ABC, 6'd20, 1'b0, 32'h0077_7ABC, 1'b0, 2'd0, "R6 global hit");
    lookup(32'h0040_0ABC, 6'd20, 1'b1, 32'h0, 1'b0, 2'd3, "R7 modify fault");

    write_entry(6'd12, 20'h00800, 6'd2, 20'h00333, 1'b0, 1'b1, 1'b0, 1'b1);
    lookup(32'h0080_0000, 6'd2, 1'b0, 32'h0, 1'b0, 2'd2, "R7 invalid fault");

    lookup(32'h8000_1234, 6'd0, 1'b1, 32'h0000_1234, 1'b1, 2'd0, "R3 kernel cached");
    lookup(32'hA0AB_CDEF, 6'd9, 1'b0, 32'h00AB_CDEF, 1'b0, 2'd0, "R4 kernel uncached");

    write_entry(6'd63, 20'hC0010, 6'd0, 20'h00042, 1'b1, 1'b1, 1'b1, 1'b1);
    lookup(32'hC001_0FFF, 6'd33, 1'b1, 32'h0004_2FFF, 1'b1, 2'd0, "R5 kernel virtual hit");
    lookup(32'hE000_0000, 6'd0, 1'b0, 32'h0, 1'b0, 2'd1, "R5 kernel virtual miss");

    write_entry(6'd30, 20'h55555, 6'd4, 20'h22222, 1'b1, 1'b1, 1'b0, 1'b0);
    write_entry(6'd20, 20'h55555, 6'd4, 20'h11111, 1'b1, 1'b1, 1'b0, 1'b1);
    lookup(32'h5555_5010, 6'd4, 1'b0, 32'h1111_1010, 1'b1, 2'd0, "R10 lowest index wins");
    drain();

    // write and lookup of the same entry on one edge
    @(negedge clk);
    set_wr(6'd5, 20'h12345, 6'd7, 20'h0F0F0, 1'b1, 1'b1, 1'b0, 1'b0);
    wr_en = 1'b1;
    req_valid = 1'b1; req_vaddr = 32'h1234_5000; req_asid = 6'd7; req_store = 1'b1;
    chk(req_ready == 1'b1, "R8 ready for collision", req_ready, 1);
    exp_q.push_back({32'hABCD_E000, 1'b1, 2'd0});
    tag_q.push_back("R8 same-cycle sees old entry");
    @(posedge clk); #1;
    wr_en = 1'b0; req_valid = 1'b0;
    lookup(32'h1234_5004, 6'd7, 1'b1, 32'h0F0F_0004, 1'b0, 2'd0, "R8 next sees new entry");
    drain();

    // stream under back-pressure
    stall_mode = 1'b1;
    for (int k = 0; k < 8; k++) begin
      lookup(32'h8000_0000 | 32'(k * 16), 6'd0, 1'b0, 32'(k * 16), 1'b1, 2'd0, "R9 backpressure kernel");
      lookup(32'h5555_5000 | 32'(k), 6'd4, 1'b0, 32'h1111_1000 | 32'(k), 1'b1, 2'd0, "R9 backpressure mapped");
    end
    stall_mode = 1'b0;
    drain();
    summary();
  end
endmodule